// File: doc/BRIEF.md
# Ethernet Receive Error Statistics Counters

This block keeps six 12-bit counters of receive-side Ethernet errors. The MAC receive path hands it one strobe per finished frame, carrying the frame's byte length and a few status flags: check sequence good, dribble bits present, VLAN tagged, truncated, and invalid data symbol seen. From these the block decides which error classes the frame belongs to and bumps those counters in the same clock edge.

A second input group watches the raw media-independent receive pins while the line is idle. The pattern it looks for is error asserted, data valid low and nibble 0xE, which marks a false carrier. The event is not counted when it happens. It is held in a one-bit latch and added to the false-carrier counter when the next frame-end strobe arrives. Only one event is kept per inter-frame gap.

Software reaches the counters through a small word-addressed register port. It can read any counter or overwrite it.

Top module: `rx_err_stats`

## Requirements
- R1: After reset, every counter reads 0 and the read data output is 0.
- R2: The alignment counter (offset 0x00) increments on a frame whose length is from 64 to 1518 bytes inclusive, with a bad check sequence and dribble bits set.
- R3: The code-error counter (offset 0x04) increments on every frame-end strobe with the invalid-symbol flag set, whatever the other flags are.
- R4: An idle false carrier is data valid 0, error 1 and nibble 0xE in one cycle. It does not change the false-carrier counter (offset 0x08) at once. The counter rises by one on the next frame-end strobe.
- R5: At most one false carrier is logged per gap between frame-end strobes, and the pending event is cleared by the strobe that logs it. An error with data valid 1, or with a nibble other than 0xE, is ignored.
- R6: The undersize counter (offset 0x0C) increments on a frame shorter than 64 bytes with a good check sequence, no dribble bits and no invalid symbol.
- R7: The oversize counter (offset 0x10) increments on a frame with a good check sequence, no dribble bits, no invalid symbol and no truncation, whose length exceeds 1518 bytes, or 1522 bytes when VLAN tagged.
- R8: The fragment counter (offset 0x14) increments on a frame shorter than 64 bytes with a bad check sequence, whether or not dribble bits are set.
- R9: A read request returns the addressed counter in bits 11:0 in the cycle after the request. Bits 31:12 read 0. Misaligned offsets and offsets above 0x14 read 0.
- R10: A write loads bits 11:0 of the write data into the addressed counter. A write wins over an increment of the same counter in the same cycle.
- R11: A counter at 0xFFF wraps to 0x000 when incremented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eof_valid | input | 1 | One-cycle frame-end strobe |
| eof_len | input | LEN_W | Frame length in bytes |
| eof_fcs_ok | input | 1 | Check sequence valid |
| eof_dribble | input | 1 | Frame had dribble bits |
| eof_vlan | input | 1 | Frame was VLAN tagged |
| eof_trunc | input | 1 | Frame was truncated at the maximum length |
| eof_bad_sym | input | 1 | Invalid data symbol seen under carrier |
| mii_dv | input | 1 | Receive data valid pin |
| mii_er | input | 1 | Receive error pin |
| mii_rxd | input | 4 | Receive data nibble |
| reg_sel | input | 1 | Register access request |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Byte offset of the counter |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid one cycle after a read |

## Verification
A frame-end strobe sampled at one rising edge changes its counters at that edge. A read issued in the following cycle returns the new value one edge later. The bench drives strobes and register requests on falling edges, issues reads only after the strobe cycle has ended, and samples the read data at the falling edge after the read request. For a false carrier, the bench reads the counter both after the idle event and after the next strobe, so the one-strobe deferral is visible at the ports.

// File: rtl/rxes_pkg.sv
package rxes_pkg;
  localparam int NUM_CNT   = 6;
  localparam int IDX_ALIGN = 0;
  localparam int IDX_CODE  = 1;
  localparam int IDX_FCAR  = 2;
  localparam int IDX_UNDER = 3;
  localparam int IDX_OVER  = 4;
  localparam int IDX_FRAG  = 5;

  typedef struct packed {
    logic fcs_ok;
    logic dribble;
    logic vlan;
    logic trunc;
    logic bad_sym;
  } frame_flags_t;
endpackage

// File: rtl/rxes_rst_sync.sv
module rxes_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_nxt;

  always_comb begin
    sync_nxt = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_nxt;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/rxes_classify.sv
module rxes_classify
  import rxes_pkg::*;
#(
  parameter int LEN_W      = 16,
  parameter int MIN_LEN    = 64,
  parameter int MAX_LEN    = 1518,
  parameter int VLAN_EXTRA = 4
) (
  input  logic               eof_valid,
  input  logic [LEN_W-1:0]   len,
  input  frame_flags_t       flags,
  output logic [NUM_CNT-1:0] inc
);
  localparam int VLAN_MAX = MAX_LEN + VLAN_EXTRA;

  logic             is_short;
  logic             in_align_range;
  logic             is_long;
  logic             well_formed;
  logic [LEN_W-1:0] long_limit;

  always_comb begin
    long_limit     = flags.vlan ? LEN_W'(VLAN_MAX) : LEN_W'(MAX_LEN);
    is_short       = (len < LEN_W'(MIN_LEN));
    in_align_range = !is_short && (len <= LEN_W'(MAX_LEN));
    is_long        = (len > long_limit);
    well_formed    = !flags.dribble && !flags.bad_sym;
  end

  always_comb begin
    inc = '0;
    if (eof_valid) begin
      inc[IDX_ALIGN] = in_align_range && !flags.fcs_ok && flags.dribble;
      inc[IDX_CODE]  = flags.bad_sym;
      inc[IDX_UNDER] = is_short && flags.fcs_ok && well_formed;
      inc[IDX_OVER]  = is_long && flags.fcs_ok && well_formed && !flags.trunc;
      inc[IDX_FRAG]  = is_short && !flags.fcs_ok;
    end
  end
endmodule

// File: rtl/rxes_fcar.sv
module rxes_fcar #(
  parameter int         NIB_W     = 4,
  parameter logic [3:0] FCAR_CODE = 4'hE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mii_dv,
  input  logic             mii_er,
  input  logic [NIB_W-1:0] mii_rxd,
  input  logic             eof_valid,
  output logic             detect,
  output logic             pending,
  output logic             fc_inc
);
  logic pend_q;
  logic pend_nxt;
  logic pend_en;

  always_comb begin
    detect   = !mii_dv && mii_er && (mii_rxd == NIB_W'(FCAR_CODE));
    pend_en  = eof_valid || detect;
    pend_nxt = eof_valid ? detect : (pend_q || detect);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (pend_en) pend_q <= pend_nxt;
  end

  assign pending = pend_q;
  assign fc_inc  = eof_valid && pend_q;
endmodule

// File: rtl/rxes_counter.sv
module rxes_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] q
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             cnt_en;

  always_comb begin
    cnt_en  = wr || inc;
    cnt_nxt = wr ? wdata : (cnt_q + CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_nxt;
  end

  assign q = cnt_q;
endmodule

// File: rtl/rx_err_stats.sv
module rx_err_stats
  import rxes_pkg::*;
#(
  parameter int LEN_W      = 16,
  parameter int CNT_W      = 12,
  parameter int ADDR_W     = 5,
  parameter int DATA_W     = 32,
  parameter int MIN_LEN    = 64,
  parameter int MAX_LEN    = 1518,
  parameter int VLAN_EXTRA = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eof_valid,
  input  logic [LEN_W-1:0]  eof_len,
  input  logic              eof_fcs_ok,
  input  logic              eof_dribble,
  input  logic              eof_vlan,
  input  logic              eof_trunc,
  input  logic              eof_bad_sym,
  input  logic              mii_dv,
  input  logic              mii_er,
  input  logic [3:0]        mii_rxd,
  input  logic              reg_sel,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata
);
  localparam int IDX_W = ADDR_W - 2;

  logic                            rst_n_s;
  frame_flags_t                    flags;
  logic [NUM_CNT-1:0]              cls_inc;
  logic [NUM_CNT-1:0]              inc_vec;
  logic [NUM_CNT-1:0]              wr_hit;
  logic [NUM_CNT-1:0][CNT_W-1:0]   cnt_q;
  logic                            fc_detect;
  logic                            fc_pend;
  logic                            fc_inc;
  logic [IDX_W-1:0]                reg_idx;
  logic                            addr_hit;
  logic [CNT_W-1:0]                rd_sel;
  logic [DATA_W-1:0]               rd_nxt;
  logic                            rd_en;
  logic [DATA_W-1:0]               rd_q;
  logic                            unused_wdata_hi;

  rxes_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  assign flags = '{fcs_ok: eof_fcs_ok, dribble: eof_dribble, vlan: eof_vlan,
                   trunc: eof_trunc, bad_sym: eof_bad_sym};

  rxes_classify #(
    .LEN_W(LEN_W), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN), .VLAN_EXTRA(VLAN_EXTRA)
  ) u_cls (
    .eof_valid (eof_valid),
    .len       (eof_len),
    .flags     (flags),
    .inc       (cls_inc)
  );

  rxes_fcar #(.NIB_W(4), .FCAR_CODE(4'hE)) u_fcar (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .mii_dv    (mii_dv),
    .mii_er    (mii_er),
    .mii_rxd   (mii_rxd),
    .eof_valid (eof_valid),
    .detect    (fc_detect),
    .pending   (fc_pend),
    .fc_inc    (fc_inc)
  );

  always_comb begin
    inc_vec           = cls_inc;
    inc_vec[IDX_FCAR] = fc_inc;
  end

  // Register decode: word offsets, counter index from the upper address bits
  always_comb begin
    reg_idx  = reg_addr[ADDR_W-1:2];
    addr_hit = (reg_addr[1:0] == 2'b00) && (int'(reg_idx) < NUM_CNT);
    rd_sel   = '0;
    for (int k = 0; k < NUM_CNT; k++) begin
      wr_hit[k] = reg_sel && reg_wr && addr_hit && (reg_idx == IDX_W'(k));
      if (reg_idx == IDX_W'(k)) rd_sel = cnt_q[k];
    end
  end

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    rxes_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n_s),
      .inc   (inc_vec[g]),
      .wr    (wr_hit[g]),
      .wdata (reg_wdata[CNT_W-1:0]),
      .q     (cnt_q[g])
    );
  end

  always_comb begin
    rd_en  = reg_sel && !reg_wr;
    rd_nxt = addr_hit ? {{(DATA_W-CNT_W){1'b0}}, rd_sel} : '0;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)   rd_q <= '0;
    else if (rd_en) rd_q <= rd_nxt;
  end

  assign reg_rdata       = rd_q;
  assign unused_wdata_hi = ^reg_wdata[DATA_W-1:CNT_W];
endmodule

// File: rtl/rx_err_stats_chk.sv
module rx_err_stats_chk
  import rxes_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int DATA_W = 32
) (
  input logic                          clk,
  input logic                          rst_n_s,
  input logic                          eof_valid,
  input logic [NUM_CNT-1:0]            inc_vec,
  input logic [NUM_CNT-1:0]            wr_hit,
  input logic [NUM_CNT-1:0][CNT_W-1:0] cnt_q,
  input logic [DATA_W-1:0]             reg_wdata,
  input logic [DATA_W-1:0]             reg_rdata,
  input logic                          fc_detect,
  input logic                          fc_pend
);
  for (genvar k = 0; k < NUM_CNT; k++) begin : g_chk
    // R10
    wr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
      wr_hit[k] |=> cnt_q[k] == $past(reg_wdata[CNT_W-1:0]));
    // R11
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
      (inc_vec[k] && !wr_hit[k]) |=> cnt_q[k] == CNT_W'($past(cnt_q[k]) + 1'b1));
    // R10
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
      (!inc_vec[k] && !wr_hit[k]) |=> $stable(cnt_q[k]));
  end

  // R9
  rd_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    reg_rdata[DATA_W-1:CNT_W] == '0);

  // R4
  fc_at_eof_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    inc_vec[IDX_FCAR] |-> eof_valid);

  // R5
  fc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (eof_valid && !fc_detect) |=> !fc_pend);

  // R6
  size_class_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $onehot0({inc_vec[IDX_ALIGN], inc_vec[IDX_UNDER], inc_vec[IDX_OVER], inc_vec[IDX_FRAG]}));
endmodule

bind rx_err_stats rx_err_stats_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n_s   (rst_n_s),
  .eof_valid (eof_valid),
  .inc_vec   (inc_vec),
  .wr_hit    (wr_hit),
  .cnt_q     (cnt_q),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .fc_detect (fc_detect),
  .fc_pend   (fc_pend)
);

// File: tb/rx_err_stats_tb.sv
`timescale 1ns/1ps
module rx_err_stats_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        eof_valid, eof_fcs_ok, eof_dribble, eof_vlan, eof_trunc, eof_bad_sym;
  logic [15:0] eof_len;
  logic        mii_dv, mii_er;
  logic [3:0]  mii_rxd;
  logic        reg_sel, reg_wr;
  logic [4:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;
  int exp_cnt [6];

  always #2.5 clk = ~clk;

  rx_err_stats u_dut (
    .clk(clk), .rst_n(rst_n), .eof_valid(eof_valid), .eof_len(eof_len),
    .eof_fcs_ok(eof_fcs_ok), .eof_dribble(eof_dribble), .eof_vlan(eof_vlan),
    .eof_trunc(eof_trunc), .eof_bad_sym(eof_bad_sym), .mii_dv(mii_dv),
    .mii_er(mii_er), .mii_rxd(mii_rxd), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  // {len[15:0], fcs_ok, dribble, vlan, trunc, bad_sym, mask[5:0]}
  // mask bits: 0 align, 1 code, 2 false carrier, 3 undersize, 4 oversize, 5 fragment
  localparam logic [26:0] VEC [16] = '{
    {16'd64,   5'b10000, 6'h00},  // clean frame
    {16'd100,  5'b01000, 6'h01},  // R2 alignment
    {16'd1518, 5'b01000, 6'h01},  // R2 upper bound
    {16'd63,   5'b01000, 6'h20},  // R8 fragment with dribble
    {16'd63,   5'b10000, 6'h08},  // R6 undersize
    {16'd63,   5'b11000, 6'h00},  // R6 dribble not well formed
    {16'd1519, 5'b10000, 6'h10},  // R7 oversize
    {16'd1519, 5'b10100, 6'h00},  // R7 VLAN limit
    {16'd1523, 5'b10100, 6'h10},  // R7 VLAN oversize
    {16'd2000, 5'b10010, 6'h00},  // R7 truncated
    {16'd100,  5'b10001, 6'h02},  // R3 code error
    {16'd40,   5'b00001, 6'h22},  // R3 R8 code plus fragment
    {16'd1519, 5'b01000, 6'h00},  // R2 above range
    {16'd64,   5'b00000, 6'h00},  // R8 bad fcs at 64 bytes
    {16'd1600, 5'b10001, 6'h02},  // R3 R7 bad symbol blocks oversize
    {16'd10,   5'b10001, 6'h02}   // R3 R6 bad symbol blocks undersize
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, got, exp);
    end
  endtask

  task automatic send_eof(input logic [15:0] len, input logic [4:0] f);
    @(negedge clk);
    eof_valid = 1'b1; eof_len = len;
    {eof_fcs_ok, eof_dribble, eof_vlan, eof_trunc, eof_bad_sym} = f;
    @(negedge clk);
    eof_valid = 1'b0; eof_len = '0;
    {eof_fcs_ok, eof_dribble, eof_vlan, eof_trunc, eof_bad_sym} = '0;
  endtask

  task automatic rd(input logic [4:0] addr, output logic [31:0] data);
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = addr;
    @(negedge clk);
    reg_sel = 1'b0;
    data = reg_rdata;
  endtask

  task automatic wr(input logic [4:0] addr, input logic [31:0] data);
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = addr; reg_wdata = data;
    @(negedge clk);
    reg_sel = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic mii_cycle(input logic dv, input logic er, input logic [3:0] d);
    @(negedge clk);
    mii_dv = dv; mii_er = er; mii_rxd = d;
    @(negedge clk);
    mii_dv = 1'b0; mii_er = 1'b0; mii_rxd = 4'h0;
  endtask

  task automatic read_all(input string tag);
    logic [31:0] d;
    for (int k = 0; k < 6; k++) begin
      rd(5'(k * 4), d);
      check(tag, d, 32'(exp_cnt[k]));
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    logic [31:0] d;
    eof_valid = 0; eof_len = 0; eof_fcs_ok = 0; eof_dribble = 0; eof_vlan = 0;
    eof_trunc = 0; eof_bad_sym = 0; mii_dv = 0; mii_er = 0; mii_rxd = 0;
    reg_sel = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    for (int k = 0; k < 6; k++) exp_cnt[k] = 0;
    do_reset();
    check("R1 rdata after reset", reg_rdata, 32'h0);
    read_all("R1 counter after reset");

    // table walk: one frame, then every counter compared
    for (int i = 0; i < 16; i++) begin
      send_eof(VEC[i][26:11], VEC[i][10:6]);
      for (int k = 0; k < 6; k++)
        if (VEC[i][k]) exp_cnt[k] = (exp_cnt[k] + 1) & 12'hFFF;
      read_all($sformatf("R2-class vector %0d (R3 R6 R7 R8)", i));
    end

    // R4: two false carriers in one gap, counted only at next strobe
    mii_cycle(1'b0, 1'b1, 4'hE);
    mii_cycle(1'b0, 1'b1, 4'hE);
    rd(5'h08, d); check("R4 not counted before strobe", d, 32'(exp_cnt[2]));
    send_eof(16'd64, 5'b10000);
    exp_cnt[2]++;
    rd(5'h08, d); check("R4 R5 one count at strobe", d, 32'(exp_cnt[2]));
    send_eof(16'd64, 5'b10000);
    rd(5'h08, d); check("R5 pending cleared", d, 32'(exp_cnt[2]));
    // R5 ignored patterns
    mii_cycle(1'b1, 1'b1, 4'hE);
    send_eof(16'd64, 5'b10000);
    rd(5'h08, d); check("R5 ignored with dv high", d, 32'(exp_cnt[2]));
    mii_cycle(1'b0, 1'b1, 4'h5);
    send_eof(16'd64, 5'b10000);
    rd(5'h08, d); check("R5 ignored with other nibble", d, 32'(exp_cnt[2]));

    // R10, R9, R11
    wr(5'h14, 32'hFFFF_FFFF);
    rd(5'h14, d); check("R10 R9 write then read", d, 32'h0000_0FFF);
    send_eof(16'd10, 5'b00000);
    rd(5'h14, d); check("R11 wrap", d, 32'h0);
    @(negedge clk);
    eof_valid = 1'b1; eof_len = 16'd10;
    reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = 5'h14; reg_wdata = 32'h0000_0123;
    @(negedge clk);
    eof_valid = 1'b0; eof_len = 0; reg_sel = 0; reg_wr = 0; reg_wdata = 0;
    rd(5'h14, d); check("R10 write wins over increment", d, 32'h0000_0123);
    rd(5'h18, d); check("R9 unmapped offset", d, 32'h0);
    rd(5'h02, d); check("R9 misaligned offset", d, 32'h0);
    rd(5'h10, d); check("R9 oversize offset", d, 32'(exp_cnt[4]));

    // R1 again after a second reset
    do_reset();
    for (int k = 0; k < 6; k++) exp_cnt[k] = 0;
    read_all("R1 counter after second reset");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule